// File: doc/BRIEF.md
# Configurable Port Pin Drive Controller

This block controls an eight-pin general-purpose port. Software programs an output latch and two mode registers over a small register bus. Bit n of each mode register selects the drive style of pin n. For every pin the block produces three pad controls: a strong pull-up, a weak keeper pull-up and a pull-down. Each pin can be push-pull, open-drain, high-impedance input, or quasi-bidirectional. In quasi-bidirectional mode a weak keeper holds a driven 1, and a strong pull-up is applied for one clock period after the pin's output value rises, so that the pin charges quickly.

Each pin can also be handed to an alternative function. That function can only pull the pin's value down, because the latch bit must hold 1 for the function's value to reach the pad. Pins selected by a parameter mask are limited to open-drain or high-impedance. On those pins the pull-up codes fall back to open-drain. Pad levels pass through a two-stage synchronizer. The sampled value can then be read over the bus and is also returned to the alternative functions.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, with default parameters, the output latch reads 8'hFF (address 0), mode register A reads 8'h08 (address 1) and mode register B reads 8'h7F (address 2).
- R2: A write with regWrEn high updates the register at regAddr on that clock edge, and the new value reads back in the next cycle. Address 3 is read-only and returns the synchronized pin levels. A write to address 3 changes no register.
- R3: Pin n's mode is {B[n],A[n]}. Code 2'b00 is open-drain: pad pull-down equals the inverse of the pin's output value, and both pull-ups are off.
- R4: Code 2'b01 is quasi-bidirectional: pull-down equals the inverse of the output value, and the weak pull-up equals the output value.
- R5: In quasi-bidirectional mode the strong pull-up is on in exactly the one cycle that follows the clock edge where the pin's output value changed from 0 to 1. It is off at all other times.
- R6: Code 2'b10 is high-impedance: all three pad controls of that pin are off.
- R7: Code 2'b11 is push-pull: the strong pull-up equals the output value for as long as it holds, pull-down is its inverse, and the weak pull-up is off.
- R8: A pin's output value is latch[n] AND (altOut[n] when altEn[n] is 1, otherwise 1).
- R9: On pins set in ODONLY_MASK (default 8'hC0, pins 6 and 7), codes 2'b01 and 2'b11 behave as open-drain, code 2'b10 stays high-impedance, and no pull-up is ever on.
- R10: A level on padIn appears at address 3 and on altIn after two clock edges, in every mode.
- R11: No pin ever has its pull-down on together with either pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register select: 0 latch, 1 mode A, 2 mode B, 3 pin levels |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | WIDTH | Write data |
| regRdData | output | WIDTH | Read data of the selected register |
| altEn | input | WIDTH | Per pin: alternative function owns the output value |
| altOut | input | WIDTH | Alternative function output values |
| altIn | output | WIDTH | Synchronized pin levels for the alternative functions |
| padIn | input | WIDTH | Raw pad levels |
| padStrongUp | output | WIDTH | Strong pull-up enables |
| padWeakUp | output | WIDTH | Weak keeper pull-up enables |
| padPullDown | output | WIDTH | Pull-down enables |

## Verification
A corrupted mode or latch bit shows on the pad controls in the same cycle it is written, as a wrong triple on the affected pin. A stale record of the previous output value shows only in the first cycle after a rising write. There the strong pull-up would be missing, doubled, or present in a mode other than quasi-bidirectional, so the bench samples that cycle and the one after it separately. A synchronizer fault moves the address-3 readback one cycle early or late, which the bench detects by reading at both cycles after every change of the pad levels.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    MODE_OPEN_DRAIN = 2'b00,
    MODE_QUASI      = 2'b01,
    MODE_HIGHZ      = 2'b10,
    MODE_PUSH_PULL  = 2'b11
  } pinMode_e;

  typedef enum logic [1:0] {
    SEL_LATCH = 2'd0,
    SEL_CFGA  = 2'd1,
    SEL_CFGB  = 2'd2,
    SEL_PINS  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrLatch;
    logic    wrCfgA;
    logic    wrCfgB;
    regSel_e rdSel;
  } portStrobe_t;

  // Pins limited to open-drain/high-impedance lose every pull-up code.
  function automatic pinMode_e limitMode(input pinMode_e reqMode, input logic restricted);
    if (restricted && (reqMode == MODE_QUASI || reqMode == MODE_PUSH_PULL))
      return MODE_OPEN_DRAIN;
    return reqMode;
  endfunction

endpackage

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
(
  input  logic [1:0]  regAddr,
  input  logic        regWrEn,
  output portStrobe_t strobe
);

  regSel_e sel;

  always_comb begin
    sel            = regSel_e'(regAddr);
    strobe.rdSel   = sel;
    strobe.wrLatch = regWrEn && (sel == SEL_LATCH);
    strobe.wrCfgA  = regWrEn && (sel == SEL_CFGA);
    strobe.wrCfgB  = regWrEn && (sel == SEL_CFGB);
  end

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_port_pkg::*;
#(
  parameter bit RESTRICTED = 1'b0
) (
  input  logic cfgA,
  input  logic cfgB,
  input  logic outVal,
  input  logic riseNow,
  output logic strongUp,
  output logic weakUp,
  output logic pullDown
);

  pinMode_e effMode;

  always_comb begin
    effMode  = limitMode(pinMode_e'({cfgB, cfgA}), RESTRICTED);
    strongUp = 1'b0;
    weakUp   = 1'b0;
    pullDown = 1'b0;
    unique case (effMode)
      MODE_OPEN_DRAIN: pullDown = ~outVal;
      MODE_QUASI: begin
        pullDown = ~outVal;
        weakUp   = outVal;
        strongUp = outVal & riseNow;
      end
      MODE_HIGHZ: ;
      MODE_PUSH_PULL: begin
        pullDown = ~outVal;
        strongUp = outVal;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter logic [WIDTH-1:0] LATCH_RST   = '1,
  parameter logic [WIDTH-1:0] CFGA_RST    = '1,
  parameter logic [WIDTH-1:0] CFGB_RST    = '0,
  parameter logic [WIDTH-1:0] ODONLY_MASK = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] altEn,
  input  logic [WIDTH-1:0] altOut,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] pinSync,
  output logic [WIDTH-1:0] strongUp,
  output logic [WIDTH-1:0] weakUp,
  output logic [WIDTH-1:0] pullDown
);

  logic [WIDTH-1:0] latchQ, cfgAQ, cfgBQ;
  logic [WIDTH-1:0] outVal, prevValQ, riseNow;
  logic [WIDTH-1:0] sync1Q, sync2Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= LATCH_RST;
      cfgAQ  <= CFGA_RST;
      cfgBQ  <= CFGB_RST;
    end else begin
      if (strobe.wrLatch) latchQ <= wrData;
      if (strobe.wrCfgA)  cfgAQ  <= wrData;
      if (strobe.wrCfgB)  cfgBQ  <= wrData;
    end
  end

  // Alternative function can only pull the value down through a latch 1.
  assign outVal  = latchQ & (~altEn | altOut);
  assign riseNow = outVal & ~prevValQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValQ <= LATCH_RST;
      sync1Q   <= '0;
      sync2Q   <= '0;
    end else begin
      prevValQ <= outVal;
      sync1Q   <= padIn;
      sync2Q   <= sync1Q;
    end
  end

  assign pinSync = sync2Q;

  always_comb begin
    unique case (strobe.rdSel)
      SEL_LATCH: rdData = latchQ;
      SEL_CFGA:  rdData = cfgAQ;
      SEL_CFGB:  rdData = cfgBQ;
      SEL_PINS:  rdData = sync2Q;
      default:   rdData = latchQ;
    endcase
  end

  for (genvar g = 0; g < WIDTH; g++) begin : gPin
    gpio_pin_drive #(.RESTRICTED(ODONLY_MASK[g])) uDrv (
      .cfgA     (cfgAQ[g]),
      .cfgB     (cfgBQ[g]),
      .outVal   (outVal[g]),
      .riseNow  (riseNow[g]),
      .strongUp (strongUp[g]),
      .weakUp   (weakUp[g]),
      .pullDown (pullDown[g])
    );
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter logic [WIDTH-1:0] LATCH_RST   = 8'hFF,
  parameter logic [WIDTH-1:0] CFGA_RST    = 8'h08,
  parameter logic [WIDTH-1:0] CFGB_RST    = 8'h7F,
  parameter logic [WIDTH-1:0] ODONLY_MASK = 8'hC0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [WIDTH-1:0] regWrData,
  output logic [WIDTH-1:0] regRdData,
  input  logic [WIDTH-1:0] altEn,
  input  logic [WIDTH-1:0] altOut,
  output logic [WIDTH-1:0] altIn,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padStrongUp,
  output logic [WIDTH-1:0] padWeakUp,
  output logic [WIDTH-1:0] padPullDown
);

  portStrobe_t strobe;

  gpio_port_ctl uCtl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  gpio_port_dp #(
    .WIDTH       (WIDTH),
    .LATCH_RST   (LATCH_RST),
    .CFGA_RST    (CFGA_RST),
    .CFGB_RST    (CFGB_RST),
    .ODONLY_MASK (ODONLY_MASK)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .altEn    (altEn),
    .altOut   (altOut),
    .padIn    (padIn),
    .pinSync  (altIn),
    .strongUp (padStrongUp),
    .weakUp   (padWeakUp),
    .pullDown (padPullDown)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int               WIDTH       = 8,
  parameter logic [WIDTH-1:0] ODONLY_MASK = '0
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       regAddr,
  input logic             regWrEn,
  input logic [WIDTH-1:0] regWrData,
  input logic [WIDTH-1:0] regRdData,
  input logic [WIDTH-1:0] padStrongUp,
  input logic [WIDTH-1:0] padWeakUp,
  input logic [WIDTH-1:0] padPullDown
);

  AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (padPullDown & (padStrongUp | padWeakUp)) == '0); // R11

  AST_ODONLY_NO_PULLUP: assert property (@(posedge clk) disable iff (!rstN)
    ((padStrongUp | padWeakUp) & ODONLY_MASK) == '0); // R9

  AST_BOOST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (padStrongUp & padWeakUp & $past(padStrongUp & padWeakUp)) == '0); // R5

  AST_LATCH_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWrEn && regAddr == 2'd0) && regAddr == 2'd0)
      |-> regRdData == $past(regWrData)); // R2

endmodule

bind gpio_port_ctrl gpio_port_chk #(.WIDTH(WIDTH), .ODONLY_MASK(ODONLY_MASK)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .regAddr     (regAddr),
  .regWrEn     (regWrEn),
  .regWrData   (regWrData),
  .regRdData   (regRdData),
  .padStrongUp (padStrongUp),
  .padWeakUp   (padWeakUp),
  .padPullDown (padPullDown)
);

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RESTR = 8'hC0;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [7:0] altEn = 8'h00, altOut = 8'h00, altIn, padIn = 8'h00;
  logic [7:0] ps, pw, pd;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctrl u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .altEn(altEn),
    .altOut(altOut), .altIn(altIn), .padIn(padIn),
    .padStrongUp(ps), .padWeakUp(pw), .padPullDown(pd)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  // returns {strong, weak, down}
  function automatic logic [2:0] expPin(logic a, logic b, logic v, logic boost, logic restr);
    logic [1:0] m;
    m = {b, a};
    if (restr && m[0]) m = 2'b00;
    case (m)
      2'b00:   return {1'b0, 1'b0, ~v};
      2'b01:   return {v & boost, v, ~v};
      2'b10:   return 3'b000;
      default: return {v, 1'b0, ~v};
    endcase
  endfunction

  task automatic checkDrive(input string tag, input logic [7:0] a, input logic [7:0] b,
                            input logic [7:0] v, input logic boost);
    logic [7:0] es, ew, ed;
    for (int i = 0; i < 8; i++) begin
      logic [2:0] t;
      t = expPin(a[i], b[i], v[i], boost, RESTR[i]);
      es[i] = t[2]; ew[i] = t[1]; ed[i] = t[0];
    end
    check8({tag, " strongUp"}, ps, es);
    check8({tag, " weakUp"}, pw, ew);
    check8({tag, " pullDown"}, pd, ed);
    check8("R11 no fight", pd & (ps | pw), 8'h00);
  endtask

  task automatic apply(input string tag, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] lat);
    logic [7:0] v, r;
    v = lat & (~altEn | altOut);
    wr(2'd0, 8'h00);
    wr(2'd1, a);
    wr(2'd2, b);
    @(negedge clk);
    wr(2'd0, lat);
    checkDrive({tag, " R5 boost cycle"}, a, b, v, 1'b1);
    @(negedge clk);
    checkDrive({tag, " steady"}, a, b, v, 1'b0);
    rd(2'd0, r);
    check8("R2 latch readback", r, lat);
  endtask

  initial begin
    logic [7:0] r, l0, l1, l2;
    logic [7:0] pats [6];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
    pats[3] = 8'h3C; pats[4] = 8'h81; pats[5] = 8'h5E;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(2'd0, r); check8("R1 latch reset", r, 8'hFF);
    rd(2'd1, r); check8("R1 cfgA reset", r, 8'h08);
    rd(2'd2, r); check8("R1 cfgB reset", r, 8'h7F);
    checkDrive("R1 reset drive", 8'h08, 8'h7F, 8'hFF, 1'b0);

    for (int m = 0; m < 4; m++) begin
      for (int al = 0; al < 3; al++) begin
        string tag;
        case (m)
          0: tag = "R3 open-drain";
          1: tag = "R4 quasi";
          2: tag = "R6 highz";
          default: tag = "R7 push-pull";
        endcase
        if (al == 1) begin altEn = 8'hF0; altOut = 8'h55; tag = {tag, " R8"}; end
        else if (al == 2) begin altEn = 8'hFF; altOut = 8'hC3; tag = {tag, " R8"}; end
        else begin altEn = 8'h00; altOut = 8'h00; end
        for (int p = 0; p < 6; p++)
          apply({tag, " R9"}, m[0] ? 8'hFF : 8'h00, m[1] ? 8'hFF : 8'h00, pats[p]);
      end
    end

    altEn = 8'h0C; altOut = 8'h04;
    for (int p = 0; p < 6; p++) begin
      apply("R4 R7 R9 mixed", 8'h5A, 8'h33, pats[p]);
      apply("R3 R6 R9 mixed", 8'hC6, 8'hE4, ~pats[p]);
    end
    altEn = 8'h00;

    // R10: synchronizer latency, sampled in high-impedance mode and push-pull
    wr(2'd1, 8'h00); wr(2'd2, 8'hFF);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] val, old;
      if (k == 8) begin wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); end
      rd(2'd3, old);
      val = 8'(k * 29 + 7) ^ 8'h96;
      padIn = val;
      @(negedge clk);
      rd(2'd3, r); check8("R10 one edge still old", r, old);
      @(negedge clk);
      rd(2'd3, r); check8("R10 two edges new", r, val);
      check8("R10 altIn", altIn, val);
    end

    // R2: address 3 ignores writes
    wr(2'd0, 8'h3A); wr(2'd1, 8'h6B); wr(2'd2, 8'h2C);
    rd(2'd0, l0); rd(2'd1, l1); rd(2'd2, l2);
    wr(2'd3, 8'hD1);
    rd(2'd0, r); check8("R2 addr3 write latch", r, l0);
    rd(2'd1, r); check8("R2 addr3 write cfgA", r, l1);
    rd(2'd2, r); check8("R2 addr3 write cfgB", r, l2);
    rd(2'd3, r); check8("R2 addr3 pins", r, padIn);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule